// File: doc/BRIEF.md
# Mode-Aware Watchdog Timer

This block watches for a stalled processor by counting ticks of a slow internal RC clock, delivered as a clock-enable strobe in the system clock domain. An 8-bit prescaler feeds a postscaler whose select input sets the time-out to 2^(8+N) ticks. When the count expires, the block looks at the current power mode: if the processor is running code, the time-out becomes a watchdog reset pulse; if the processor is idle or asleep, it becomes a wake pulse that brings the processor back to a run mode, and no reset is raised.

The whole count (prescaler and postscaler) restarts on a software clear strobe, on entry to sleep, and on loss of the selected clock when the fail-safe clock monitor is enabled. While the watchdog is disabled the count is held at zero. A separate output asks the RC oscillator to keep running whenever either the watchdog or the clock monitor is enabled, so that the count goes on during sleep.

Top module: `mode_watchdog`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `wake_pulse` and `reset_pulse` are both low.
- R2: With `post_sel` = N, a time-out fires after exactly 2^(8+N) clock edges at which `rc_tick` is high, counted from the last edge at which the count was restarted; edges with `rc_tick` low do not count.
- R3: A time-out while `mode_in` is 2'b00 (run) or 2'b11 (treated as run) raises `reset_pulse` and leaves `wake_pulse` low.
- R4: A time-out while `mode_in` is 2'b01 (idle) or 2'b10 (sleep) raises `wake_pulse` and leaves `reset_pulse` low.
- R5: Each pulse lasts one cycle; the count restarts by itself, so with no other event the next time-out follows a full period later.
- R6: An edge with `clr_strobe` high restarts the count from zero.
- R7: An edge with `sleep_strobe` high restarts the count from zero.
- R8: An edge with `clk_lost` high restarts the count only when `fscm_en` is high; with `fscm_en` low, `clk_lost` has no effect on time-out timing.
- R9: While `wdt_en` is low no pulse is produced and the count is held at zero, so re-enabling starts a full period.
- R10: `keep_rc_on` equals `wdt_en` OR `fscm_en` in every power mode, sleep included.
- R11: The routing of R3/R4 uses `mode_in` at the edge where the time-out occurs, not the mode at the start of the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rc_tick | input | 1 | One-cycle enable per RC oscillator period |
| wdt_en | input | 1 | Watchdog enable |
| clr_strobe | input | 1 | Software clear of the watchdog |
| sleep_strobe | input | 1 | Sleep entry strobe, also clears the count |
| clk_lost | input | 1 | Selected clock has failed |
| fscm_en | input | 1 | Fail-safe clock monitor enable |
| mode_in | input | 2 | Power mode: 00 run, 01 idle, 10 sleep, 11 run |
| post_sel | input | 4 | Postscaler select N, time-out 2^(8+N) ticks |
| wake_pulse | output | 1 | One-cycle wake request on time-out in idle or sleep |
| reset_pulse | output | 1 | One-cycle watchdog reset on time-out in run |
| keep_rc_on | output | 1 | Request to keep the RC oscillator running |

## Verification
A wrong count or a missed clear shows up only at the next time-out, as a pulse arriving early or late by a number of cycles equal to the error, so every scenario compares the exact cycle of each pulse against a period computed from the restart edge. A wrong routing decision shows as the other pulse in that same cycle. A clear path that is wired too broadly (for example clock loss without the monitor enabled) shows as a pulse shifted later by the cycles elapsed before the spurious clear, and a disabled counter that still advances shows as a stray pulse or an early pulse after re-enable.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int PRE_W = 8;
    localparam int SEL_W = 4;

    typedef enum logic [1:0] {
        PM_RUN   = 2'b00,
        PM_IDLE  = 2'b01,
        PM_SLEEP = 2'b10,
        PM_RSVD  = 2'b11
    } pmode_e;

    typedef struct packed {
        logic wake;
        logic rst;
    } tout_s;

    function automatic logic cpu_halted(pmode_e m);
        return (m == PM_IDLE) || (m == PM_SLEEP);
    endfunction

    function automatic tout_s route_tout(logic fire, pmode_e m);
        tout_s r;
        r.wake = fire &  cpu_halted(m);
        r.rst  = fire & ~cpu_halted(m);
        return r;
    endfunction

endpackage

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
    parameter int W = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic tick,
    output logic carry
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + W'(1);
        end
    end

    assign carry = tick & ~clr & (&cnt_q);
endmodule

// File: rtl/wdg_postscaler.sv
module wdg_postscaler #(
    parameter int SEL_W  = 4,
    parameter int POST_W = (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             carry,
    input  logic [SEL_W-1:0] sel,
    output logic             fire
);
    logic [POST_W-1:0] cnt_q;
    logic [POST_W-1:0] mask;

    for (genvar i = 0; i < POST_W; i++) begin : g_mask
        assign mask[i] = (sel > SEL_W'(i));
    end

    assign fire = carry & ((cnt_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || clr || fire) begin
            cnt_q <= '0;
        end else if (carry) begin
            cnt_q <= cnt_q + POST_W'(1);
        end
    end
endmodule

// File: rtl/wdg_router.sv
module wdg_router
    import wdg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   fire,
    input  pmode_e mode,
    output logic   wake_pulse,
    output logic   reset_pulse
);
    tout_s nxt, q;

    always_comb nxt = route_tout(fire, mode);

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    assign wake_pulse  = q.wake;
    assign reset_pulse = q.rst;
endmodule

// File: rtl/mode_watchdog.sv
module mode_watchdog
    import wdg_pkg::*;
#(
    parameter int PRE_BITS = wdg_pkg::PRE_W,
    parameter int SEL_BITS = wdg_pkg::SEL_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rc_tick,
    input  logic                wdt_en,
    input  logic                clr_strobe,
    input  logic                sleep_strobe,
    input  logic                clk_lost,
    input  logic                fscm_en,
    input  logic [1:0]          mode_in,
    input  logic [SEL_BITS-1:0] post_sel,
    output logic                wake_pulse,
    output logic                reset_pulse,
    output logic                keep_rc_on
);
    localparam int POST_BITS = (1 << SEL_BITS) - 1;

    logic   restart;
    logic   pre_carry;
    logic   fire;
    pmode_e mode;

    assign mode    = pmode_e'(mode_in);
    assign restart = clr_strobe | sleep_strobe | (clk_lost & fscm_en) | ~wdt_en;

    wdg_prescaler #(.W(PRE_BITS)) u_pre (
        .clk   (clk),
        .rst   (rst),
        .clr   (restart),
        .tick  (rc_tick),
        .carry (pre_carry)
    );

    wdg_postscaler #(.SEL_W(SEL_BITS), .POST_W(POST_BITS)) u_post (
        .clk   (clk),
        .rst   (rst),
        .clr   (restart),
        .carry (pre_carry),
        .sel   (post_sel),
        .fire  (fire)
    );

    wdg_router u_route (
        .clk         (clk),
        .rst         (rst),
        .fire        (fire),
        .mode        (mode),
        .wake_pulse  (wake_pulse),
        .reset_pulse (reset_pulse)
    );

    assign keep_rc_on = wdt_en | fscm_en;
endmodule

// File: rtl/wdg_checker.sv
module wdg_checker (
    input logic       clk,
    input logic       rst,
    input logic       wdt_en,
    input logic       clr_strobe,
    input logic       sleep_strobe,
    input logic       clk_lost,
    input logic       fscm_en,
    input logic [1:0] mode_in,
    input logic       wake_pulse,
    input logic       reset_pulse,
    input logic       keep_rc_on
);
    p_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(wake_pulse && reset_pulse));

    p_wake_mode_r4: assert property (@(posedge clk) disable iff (rst)
        wake_pulse |-> ($past(mode_in) == 2'b01 || $past(mode_in) == 2'b10));

    p_rst_mode_r3: assert property (@(posedge clk) disable iff (rst)
        reset_pulse |-> ($past(mode_in) == 2'b00 || $past(mode_in) == 2'b11));

    p_one_cycle_r5: assert property (@(posedge clk) disable iff (rst)
        (wake_pulse || reset_pulse) |=> !(wake_pulse || reset_pulse));

    p_clr_r6: assert property (@(posedge clk) disable iff (rst)
        $past(clr_strobe) |-> !(wake_pulse || reset_pulse));

    p_sleep_r7: assert property (@(posedge clk) disable iff (rst)
        $past(sleep_strobe) |-> !(wake_pulse || reset_pulse));

    p_loss_r8: assert property (@(posedge clk) disable iff (rst)
        $past(clk_lost && fscm_en) |-> !(wake_pulse || reset_pulse));

    p_off_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(wdt_en) |-> !(wake_pulse || reset_pulse));

    p_keep_rc_r10: assert property (@(posedge clk) disable iff (rst)
        (wdt_en || fscm_en) |-> keep_rc_on);
endmodule

bind mode_watchdog wdg_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .wdt_en       (wdt_en),
    .clr_strobe   (clr_strobe),
    .sleep_strobe (sleep_strobe),
    .clk_lost     (clk_lost),
    .fscm_en      (fscm_en),
    .mode_in      (mode_in),
    .wake_pulse   (wake_pulse),
    .reset_pulse  (reset_pulse),
    .keep_rc_on   (keep_rc_on)
);

// File: tb/mode_watchdog_tb.sv
module mode_watchdog_tb;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst;
    logic       rc_tick, wdt_en, clr_strobe, sleep_strobe, clk_lost, fscm_en;
    logic [1:0] mode_in;
    logic [3:0] post_sel;
    logic       wake_pulse, reset_pulse, keep_rc_on;

    int  total = 0;
    int  bad = 0;
    int  cyc = 0;
    bit  tick_div = 0;
    bit  done = 0;

    typedef struct {
        int    at;
        bit    wake;
        string req;
    } exp_t;
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    mode_watchdog u_dut (
        .clk(clk), .rst(rst), .rc_tick(rc_tick), .wdt_en(wdt_en),
        .clr_strobe(clr_strobe), .sleep_strobe(sleep_strobe),
        .clk_lost(clk_lost), .fscm_en(fscm_en), .mode_in(mode_in),
        .post_sel(post_sel), .wake_pulse(wake_pulse),
        .reset_pulse(reset_pulse), .keep_rc_on(keep_rc_on)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string req, int act, int exp, string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic expect_at(int at, bit wake, string req);
        exp_t e;
        e.at = at; e.wake = wake; e.req = req;
        q.push_back(e);
    endtask

    // Monitor: pops the scoreboard as pulses appear.
    always @(negedge clk) begin
        if (!rst) begin
            if (wake_pulse || reset_pulse) begin
                if (q.size() == 0) begin
                    check("R9", 1, 0, "unexpected pulse");
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(e.req, cyc, e.at, "pulse cycle");
                    check(e.req, int'(wake_pulse), int'(e.wake), "wake_pulse");
                    check(e.req, int'(reset_pulse), int'(!e.wake), "reset_pulse");
                end
            end else if (q.size() > 0 && cyc > q[0].at) begin
                exp_t e;
                e = q.pop_front();
                check(e.req, cyc, e.at, "missing pulse");
            end
        end
    end

    task automatic step();
        @(negedge clk);
        if (tick_div) rc_tick = ~rc_tick;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // Enable at a negedge; count starts on the next edge.
    task automatic enable(output int e);
        step();
        wdt_en = 1'b1;
        e = cyc;
    endtask

    task automatic disable_wdt();
        step();
        wdt_en = 1'b0;
        step();
    endtask

    initial begin
        int e;
        rst = 1; rc_tick = 1; wdt_en = 0; clr_strobe = 0; sleep_strobe = 0;
        clk_lost = 0; fscm_en = 0; mode_in = 2'b00; post_sel = 4'd0;
        idle(3);
        check("R1", int'(wake_pulse), 0, "wake in reset");
        check("R1", int'(reset_pulse), 0, "reset in reset");
        rst = 0;
        step();
        check("R1", int'(wake_pulse | reset_pulse), 0, "pulse after reset");
        check("R10", int'(keep_rc_on), 0, "keep_rc both off");

        // R2 R3 R5: run mode, two back-to-back periods
        mode_in = 2'b00;
        enable(e);
        expect_at(e + 256, 0, "R3");
        expect_at(e + 512, 0, "R5");
        idle(520);
        disable_wdt();

        // R2 R4: idle mode, post_sel 1 -> 512 ticks
        mode_in = 2'b01; post_sel = 4'd1;
        enable(e);
        expect_at(e + 512, 1, "R4");
        idle(530);
        disable_wdt();

        // R2: post_sel 2 -> 1024 ticks, reserved mode treated as run (R3)
        mode_in = 2'b11; post_sel = 4'd2;
        enable(e);
        expect_at(e + 1024, 0, "R2");
        idle(1040);
        disable_wdt();
        post_sel = 4'd0;

        // R7: sleep strobe restarts, sleep mode gives wake
        mode_in = 2'b10;
        enable(e);
        idle(100);
        check("R10", int'(keep_rc_on), 1, "keep_rc in sleep");
        sleep_strobe = 1; step(); e = cyc; sleep_strobe = 0;
        expect_at(e + 256, 1, "R7");
        idle(270);
        disable_wdt();

        // R6: clear strobe restarts
        mode_in = 2'b00;
        enable(e);
        idle(150);
        clr_strobe = 1; step(); e = cyc; clr_strobe = 0;
        expect_at(e + 256, 0, "R6");
        idle(270);
        disable_wdt();

        // R8: clock loss ignored without monitor
        fscm_en = 0;
        enable(e);
        expect_at(e + 256, 0, "R8");
        idle(100);
        clk_lost = 1; step(); clk_lost = 0;
        idle(170);
        disable_wdt();

        // R8: clock loss restarts with monitor enabled
        fscm_en = 1;
        enable(e);
        idle(100);
        clk_lost = 1; step(); e = cyc; clk_lost = 0;
        expect_at(e + 256, 0, "R8");
        idle(270);
        disable_wdt();
        fscm_en = 0;

        // R9: disable holds, re-enable gives full period
        enable(e);
        idle(200);
        wdt_en = 0;
        idle(300);
        check("R9", int'(wake_pulse | reset_pulse), 0, "pulse while disabled");
        check("R9", q.size(), 0, "scoreboard empty while disabled");
        wdt_en = 1; e = cyc;
        expect_at(e + 256, 0, "R9");
        idle(270);
        disable_wdt();

        // R11: mode changes mid-period, routing uses mode at time-out
        mode_in = 2'b00;
        enable(e);
        expect_at(e + 256, 1, "R11");
        idle(100);
        mode_in = 2'b01;
        idle(170);
        disable_wdt();

        // R2: rc_tick high every other cycle -> 511 edges
        mode_in = 2'b00;
        step();
        rc_tick = 1; wdt_en = 1; e = cyc; tick_div = 1;
        expect_at(e + 511, 0, "R2");
        idle(530);
        tick_div = 0; rc_tick = 1;
        disable_wdt();

        // R10: keep_rc across modes and enables
        mode_in = 2'b10;
        fscm_en = 1; step();
        check("R10", int'(keep_rc_on), 1, "fscm only, sleep");
        fscm_en = 0; step();
        check("R10", int'(keep_rc_on), 0, "both off, sleep");
        mode_in = 2'b01; wdt_en = 1; step();
        check("R10", int'(keep_rc_on), 1, "wdt only, idle");
        wdt_en = 0; step();

        idle(5);
        check("R5", q.size(), 0, "scoreboard drained");
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL R1 watchdog expired: actual=%0d expected=%0d", cyc, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule